// File: doc/BRIEF.md
# SR-IOV Capability Register File

This block holds the single-root I/O virtualization extended capability of a physical function as a small register file behind a configuration read/write port. Software addresses it with a byte address inside the configuration space, four byte enables, a 32-bit write word and a write strobe. Reads return the addressed dword combinationally. The block outputs the current VF enable state and the number of virtual functions that are active.

Each writable field is guarded by its own constant write mask. Fixed fields are set by parameters and cannot be changed by writes. These are the capability header, the initial and total VF counts, the routing offset and stride, the VF device identifier and the supported page sizes.

A write that reaches the control byte and raises VF enable takes a snapshot of the requested VF count as the active count. A write that drops VF enable while functions are active clears both the active count and the requested count. Six VF BAR slots carry masks derived from the aperture size. A slot bitmap chooses which slots start a 64-bit prefetchable memory BAR that spans the slot and the slot after it.

Top module: `sriov_cap_top`

## Requirements
- R1: After reset, control reads 0, requested VF count reads 0, system page size reads 0x1, each 64-bit BAR low dword reads 0x0000000C, its high dword reads 0, and vfEnable and activeVfs are 0.
- R2: Read-only dwords hold their fixed values and ignore writes. At +0x00 is 0x00010010 with next pointer 0. At +0x0C is {TotalVFs, InitialVFs} = 0x00080004. At +0x14 is {stride, offset} = 0x00020080. At +0x18 is {device id, 0} = 0x10CA0000. At +0x1C is 0x00000553.
- R3: The control word at +0x08 bits 15:0 only lets bit 0 (VF enable), bit 3 (VF memory space) and bit 4 (ARI hierarchy) be written. The status half in bits 31:16 reads 0.
- R4: The requested VF count at +0x10 bits 15:0 is fully writable, and bits 31:16 read 0.
- R5: The system page size at +0x20 only lets the bits of 0x553 be written.
- R6: Byte enable k gates byte k (bits 8k+7:8k) of every write, on top of the field mask.
- R7: When activeVfs is 0, a write to +0x08 with byte enable 0 set and data bit 0 = 1 sets vfEnable. On the next cycle activeVfs equals the requested VF count held before that write.
- R8: When activeVfs is nonzero, a write to +0x08 with byte enable 0 set and data bit 0 = 0 clears vfEnable and activeVfs. The requested VF count also reads 0 afterwards.
- R9: activeVfs changes on no other event: writing the requested VF count, rewriting VF enable as 1, or a control write with byte enable 0 clear leaves it unchanged.
- R10: Writes outside [base, base+0x40) change nothing, and reads there return 0.
- R11: In a 64-bit BAR (slots 0 and 3, at +0x24/+0x28 and +0x30/+0x34), the low dword bits 13:0 always read 0xC and bits 31:14 are writable. The high dword is fully writable. Slots 2 and 5 (+0x2C, +0x38) always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgAddr | input | 12 | Configuration byte address (dword aligned use) |
| cfgByteEn | input | 4 | Byte enables of the write |
| cfgWdata | input | 32 | Write data |
| cfgWrEn | input | 1 | Write strobe |
| cfgRdata | output | 32 | Read data of the addressed dword |
| vfEnable | output | 1 | Current VF enable bit |
| activeVfs | output | 16 | Number of active virtual functions |

## Verification
A wrong mask or byte-lane decode shows up on the read port one cycle after the offending write, as bits that stick or bits that change when they should not. A wrong enable decision shows on activeVfs and vfEnable at the first clock edge after the control write. It also shows on the requested VF count, which reads nonzero after a disable. The bench therefore reads back every field after each write and samples both status outputs one cycle after each control write. That includes writes outside the window and writes that leave byte 0 disabled.

// File: rtl/sriov_cap_pkg.sv
package sriov_cap_pkg;
  localparam int CAP_BYTES = 64;
  localparam int BAR_SLOTS = 6;

  localparam logic [3:0] IDX_HDR   = 4'd0;
  localparam logic [3:0] IDX_CAPS  = 4'd1;
  localparam logic [3:0] IDX_CTRL  = 4'd2;
  localparam logic [3:0] IDX_VFCNT = 4'd3;
  localparam logic [3:0] IDX_NUM   = 4'd4;
  localparam logic [3:0] IDX_ROUTE = 4'd5;
  localparam logic [3:0] IDX_DID   = 4'd6;
  localparam logic [3:0] IDX_SUPPG = 4'd7;
  localparam logic [3:0] IDX_SYSPG = 4'd8;
  localparam logic [3:0] IDX_BAR0  = 4'd9;

  localparam logic [15:0] CTRL_WMASK  = 16'h0019;
  localparam logic [31:0] PAGE_WMASK  = 32'h0000_0553;
  localparam logic [31:0] SUP_PAGES   = 32'h0000_0553;
  localparam logic [31:0] BAR_TYPE64P = 32'h0000_000C;

  typedef struct packed {
    logic                 wrCtrl;
    logic                 wrNum;
    logic                 wrPage;
    logic [BAR_SLOTS-1:0] wrBar;
    logic                 latchActive;
    logic                 dropActive;
    logic                 rdHit;
    logic [3:0]           rdIdx;
  } cap_strobe_t;

  function automatic logic [31:0] laneMask(input logic [3:0] be);
    return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  endfunction
endpackage

// File: rtl/sriov_cap_ctrl.sv
module sriov_cap_ctrl
  import sriov_cap_pkg::*;
#(
  parameter int                ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] CAP_BASE = 12'h160
) (
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [3:0]        cfgByteEn,
  input  logic              vfeReq,
  input  logic              cfgWrEn,
  input  logic              activeNz,
  output cap_strobe_t       stb
);
  logic [ADDR_W-1:0] offs;
  logic              inWindow;
  logic              wrHit;
  logic [3:0]        idx;
  logic              ctrlByteWr;

  assign offs     = cfgAddr - CAP_BASE;
  assign inWindow = (cfgAddr >= CAP_BASE) && (offs < ADDR_W'(CAP_BYTES));
  assign idx      = offs[5:2];
  assign wrHit    = cfgWrEn && inWindow;

  always_comb begin
    stb        = '0;
    stb.rdHit  = inWindow;
    stb.rdIdx  = idx;
    stb.wrCtrl = wrHit && (idx == IDX_CTRL);
    stb.wrNum  = wrHit && (idx == IDX_NUM);
    stb.wrPage = wrHit && (idx == IDX_SYSPG);
    for (int i = 0; i < BAR_SLOTS; i++) begin
      stb.wrBar[i] = wrHit && (idx == IDX_BAR0 + 4'(i));
    end
    ctrlByteWr      = stb.wrCtrl && cfgByteEn[0];
    stb.latchActive = ctrlByteWr && !activeNz && vfeReq;
    stb.dropActive  = ctrlByteWr && activeNz && !vfeReq;
  end
endmodule

// File: rtl/sriov_cap_regs.sv
module sriov_cap_regs
  import sriov_cap_pkg::*;
#(
  parameter logic [11:0]          NEXT_CAP          = 12'h000,
  parameter logic [15:0]          INITIAL_VFS       = 16'd4,
  parameter logic [15:0]          TOTAL_VFS         = 16'd8,
  parameter logic [15:0]          VF_OFFSET         = 16'h0080,
  parameter logic [15:0]          VF_STRIDE         = 16'h0002,
  parameter logic [15:0]          VF_DEV_ID         = 16'h10CA,
  parameter int                   BAR_APERTURE_LOG2 = 14,
  parameter logic [BAR_SLOTS-1:0] BAR64_SLOTS       = 6'b001001
) (
  input  logic        clk,
  input  logic        rstN,
  input  cap_strobe_t stb,
  input  logic [3:0]  cfgByteEn,
  input  logic [31:0] cfgWdata,
  output logic [31:0] cfgRdata,
  output logic        vfEnable,
  output logic [15:0] activeVfs,
  output logic [15:0] numVfsQ,
  output logic        activeNz
);
  localparam logic [31:0] LO_MASK = ~((32'd1 << BAR_APERTURE_LOG2) - 32'd1);

  logic [31:0] beMask;
  logic [15:0] ctrlQ;
  logic [31:0] pageQ;
  logic [15:0] activeQ;
  logic [31:0] barVal [BAR_SLOTS];

  assign beMask = laneMask(cfgByteEn);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ   <= '0;
      numVfsQ <= '0;
      pageQ   <= 32'h1;
      activeQ <= '0;
    end else begin
      if (stb.wrCtrl)
        ctrlQ <= (ctrlQ & ~(CTRL_WMASK & beMask[15:0])) | (cfgWdata[15:0] & CTRL_WMASK & beMask[15:0]);
      if (stb.dropActive)
        numVfsQ <= '0;
      else if (stb.wrNum)
        numVfsQ <= (numVfsQ & ~beMask[15:0]) | (cfgWdata[15:0] & beMask[15:0]);
      if (stb.wrPage)
        pageQ <= (pageQ & ~(PAGE_WMASK & beMask)) | (cfgWdata & PAGE_WMASK & beMask);
      if (stb.latchActive)
        activeQ <= numVfsQ;
      else if (stb.dropActive)
        activeQ <= '0;
    end
  end

  for (genvar g = 0; g < BAR_SLOTS; g++) begin : g_bar
    localparam bit IS_LO = BAR64_SLOTS[g];
    localparam bit IS_HI = (g > 0) ? BAR64_SLOTS[(g > 0) ? g - 1 : 0] : 1'b0;
    localparam logic [31:0] WMASK = IS_LO ? LO_MASK : (IS_HI ? 32'hFFFF_FFFF : 32'h0);
    localparam logic [31:0] RSTV  = IS_LO ? BAR_TYPE64P : 32'h0;
    logic [31:0] slotQ;
    always_ff @(posedge clk) begin
      if (!rstN)
        slotQ <= RSTV;
      else if (stb.wrBar[g])
        slotQ <= (slotQ & ~(WMASK & beMask)) | (cfgWdata & WMASK & beMask);
    end
    assign barVal[g] = slotQ;
  end

  always_comb begin
    logic [31:0] rd;
    rd = '0;
    case (stb.rdIdx)
      IDX_HDR:   rd = {NEXT_CAP, 4'h1, 16'h0010};
      IDX_CAPS:  rd = '0;
      IDX_CTRL:  rd = {16'h0, ctrlQ};
      IDX_VFCNT: rd = {TOTAL_VFS, INITIAL_VFS};
      IDX_NUM:   rd = {16'h0, numVfsQ};
      IDX_ROUTE: rd = {VF_STRIDE, VF_OFFSET};
      IDX_DID:   rd = {VF_DEV_ID, 16'h0};
      IDX_SUPPG: rd = SUP_PAGES;
      IDX_SYSPG: rd = pageQ;
      default: begin
        for (int i = 0; i < BAR_SLOTS; i++)
          if (stb.rdIdx == IDX_BAR0 + 4'(i)) rd = barVal[i];
      end
    endcase
    cfgRdata = stb.rdHit ? rd : 32'h0;
  end

  assign vfEnable  = ctrlQ[0];
  assign activeVfs = activeQ;
  assign activeNz  = |activeQ;
endmodule

// File: rtl/sriov_cap_top.sv
module sriov_cap_top
  import sriov_cap_pkg::*;
#(
  parameter int                   ADDR_W            = 12,
  parameter logic [ADDR_W-1:0]    CAP_BASE          = 12'h160,
  parameter logic [11:0]          NEXT_CAP          = 12'h000,
  parameter logic [15:0]          INITIAL_VFS       = 16'd4,
  parameter logic [15:0]          TOTAL_VFS         = 16'd8,
  parameter logic [15:0]          VF_OFFSET         = 16'h0080,
  parameter logic [15:0]          VF_STRIDE         = 16'h0002,
  parameter logic [15:0]          VF_DEV_ID         = 16'h10CA,
  parameter int                   BAR_APERTURE_LOG2 = 14,
  parameter logic [BAR_SLOTS-1:0] BAR64_SLOTS       = 6'b001001
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [3:0]        cfgByteEn,
  input  logic [31:0]       cfgWdata,
  input  logic              cfgWrEn,
  output logic [31:0]       cfgRdata,
  output logic              vfEnable,
  output logic [15:0]       activeVfs
);
  cap_strobe_t stb;
  logic        activeNz;
  logic [15:0] numVfsQ;

  sriov_cap_ctrl #(.ADDR_W(ADDR_W), .CAP_BASE(CAP_BASE)) u_ctrl (
    .cfgAddr  (cfgAddr),
    .cfgByteEn(cfgByteEn),
    .vfeReq   (cfgWdata[0]),
    .cfgWrEn  (cfgWrEn),
    .activeNz (activeNz),
    .stb      (stb)
  );

  sriov_cap_regs #(
    .NEXT_CAP(NEXT_CAP), .INITIAL_VFS(INITIAL_VFS), .TOTAL_VFS(TOTAL_VFS),
    .VF_OFFSET(VF_OFFSET), .VF_STRIDE(VF_STRIDE), .VF_DEV_ID(VF_DEV_ID),
    .BAR_APERTURE_LOG2(BAR_APERTURE_LOG2), .BAR64_SLOTS(BAR64_SLOTS)
  ) u_regs (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .cfgByteEn(cfgByteEn),
    .cfgWdata (cfgWdata),
    .cfgRdata (cfgRdata),
    .vfEnable (vfEnable),
    .activeVfs(activeVfs),
    .numVfsQ  (numVfsQ),
    .activeNz (activeNz)
  );
endmodule

// File: rtl/sriov_cap_chk.sv
module sriov_cap_chk #(
  parameter int                ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] CAP_BASE = 12'h160
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] cfgAddr,
  input logic [3:0]        cfgByteEn,
  input logic [31:0]       cfgWdata,
  input logic              cfgWrEn,
  input logic              vfEnable,
  input logic [15:0]       activeVfs,
  input logic [15:0]       numVfs
);
  logic [ADDR_W:0] addrX;
  logic [ADDR_W:0] baseX;
  logic            inWin;
  logic            ctrlByteWr;

  assign addrX      = {1'b0, cfgAddr};
  assign baseX      = {1'b0, CAP_BASE};
  assign inWin      = (addrX >= baseX) && (addrX < baseX + (ADDR_W+1)'(64));
  assign ctrlByteWr = cfgWrEn && cfgByteEn[0] && (addrX[ADDR_W:2] == ((baseX + (ADDR_W+1)'(8)) >> 2));

  p_enable_latch_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlByteWr && cfgWdata[0] && activeVfs == 16'd0) |=> (vfEnable && activeVfs == $past(numVfs)));

  p_active_needs_enable_r7: assert property (@(posedge clk) disable iff (!rstN)
    (activeVfs != 16'd0) |-> vfEnable);

  p_disable_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlByteWr && !cfgWdata[0] && activeVfs != 16'd0) |=> (!vfEnable && activeVfs == 16'd0 && numVfs == 16'd0));

  p_active_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlByteWr |=> $stable(activeVfs));

  p_outside_ignored_r10: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && !inWin) |=> ($stable(numVfs) && $stable(vfEnable) && $stable(activeVfs)));
endmodule

bind sriov_cap_top sriov_cap_chk #(.ADDR_W(ADDR_W), .CAP_BASE(CAP_BASE)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .cfgAddr  (cfgAddr),
  .cfgByteEn(cfgByteEn),
  .cfgWdata (cfgWdata),
  .cfgWrEn  (cfgWrEn),
  .vfEnable (vfEnable),
  .activeVfs(activeVfs),
  .numVfs   (numVfsQ)
);

// File: tb/test_sriov_cap_top.sv
`timescale 1ns/1ps
module test_sriov_cap_top;
  localparam logic [11:0] BASE = 12'h160;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] cfgAddr = '0;
  logic [3:0]  cfgByteEn = '0;
  logic [31:0] cfgWdata = '0;
  logic        cfgWrEn = 1'b0;
  logic [31:0] cfgRdata;
  logic        vfEnable;
  logic [15:0] activeVfs;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  sriov_cap_top i_sriov_cap_top (
    .clk(clk), .rstN(rstN), .cfgAddr(cfgAddr), .cfgByteEn(cfgByteEn),
    .cfgWdata(cfgWdata), .cfgWrEn(cfgWrEn), .cfgRdata(cfgRdata),
    .vfEnable(vfEnable), .activeVfs(activeVfs)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic cfgWrite(input logic [11:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfgAddr = a; cfgByteEn = be; cfgWdata = d; cfgWrEn = 1'b1;
    @(negedge clk);
    cfgWrEn = 1'b0; cfgByteEn = '0;
  endtask

  task automatic cfgRead(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    cfgAddr = a; cfgWrEn = 1'b0;
    #1 d = cfgRdata;
  endtask

  task automatic readCheck(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d;
    cfgRead(a, d);
    check(req, d, exp);
  endtask

  task automatic testReset();
    readCheck("R1 ctrl", BASE + 12'h08, 32'h0);
    readCheck("R1 numvfs", BASE + 12'h10, 32'h0);
    readCheck("R1 pagesize", BASE + 12'h20, 32'h1);
    readCheck("R1 bar0 lo", BASE + 12'h24, 32'hC);
    readCheck("R1 bar0 hi", BASE + 12'h28, 32'h0);
    readCheck("R1 bar3 lo", BASE + 12'h30, 32'hC);
    check("R1 vfEnable", {31'h0, vfEnable}, 32'h0);
    check("R1 activeVfs", {16'h0, activeVfs}, 32'h0);
  endtask

  task automatic testConstants();
    logic [11:0] offs [5] = '{12'h00, 12'h0C, 12'h14, 12'h18, 12'h1C};
    logic [31:0] vals [5] = '{32'h0001_0010, 32'h0008_0004, 32'h0002_0080, 32'h10CA_0000, 32'h0000_0553};
    for (int i = 0; i < 5; i++) begin
      readCheck("R2 constant", BASE + offs[i], vals[i]);
      cfgWrite(BASE + offs[i], 4'hF, 32'hFFFF_FFFF);
      readCheck("R2 constant after write", BASE + offs[i], vals[i]);
    end
  endtask

  task automatic testCtrlMask();
    cfgWrite(BASE + 12'h08, 4'hF, 32'hFFFF_FFFE);
    readCheck("R3 ctrl mask", BASE + 12'h08, 32'h0000_0018);
    check("R3 no enable", {31'h0, vfEnable}, 32'h0);
    cfgWrite(BASE + 12'h08, 4'hF, 32'h0);
    readCheck("R3 ctrl cleared", BASE + 12'h08, 32'h0);
  endtask

  task automatic testNumVfs();
    cfgWrite(BASE + 12'h10, 4'hF, 32'hFFFF_FFFF);
    readCheck("R4 numvfs full", BASE + 12'h10, 32'h0000_FFFF);
    cfgWrite(BASE + 12'h10, 4'hF, 32'h0);
    readCheck("R4 numvfs zero", BASE + 12'h10, 32'h0);
  endtask

  task automatic testPage();
    cfgWrite(BASE + 12'h20, 4'hF, 32'hFFFF_FFFF);
    readCheck("R5 page mask", BASE + 12'h20, 32'h0000_0553);
    cfgWrite(BASE + 12'h20, 4'hF, 32'h0);
    readCheck("R5 page zero", BASE + 12'h20, 32'h0);
  endtask

  task automatic testByteEn();
    cfgWrite(BASE + 12'h10, 4'hF, 32'h0000_1234);
    cfgWrite(BASE + 12'h10, 4'h1, 32'h0000_AB00);
    readCheck("R6 numvfs low lane", BASE + 12'h10, 32'h0000_1200);
    cfgWrite(BASE + 12'h28, 4'b0101, 32'hAABB_CCDD);
    readCheck("R6 bar hi lanes", BASE + 12'h28, 32'h00BB_00DD);
    cfgWrite(BASE + 12'h28, 4'hF, 32'h0);
  endtask

  task automatic testEnable();
    cfgWrite(BASE + 12'h10, 4'hF, 32'd5);
    cfgWrite(BASE + 12'h08, 4'h1, 32'h1);
    check("R7 vfEnable set", {31'h0, vfEnable}, 32'h1);
    check("R7 active latched", {16'h0, activeVfs}, 32'd5);
    readCheck("R7 ctrl reads enable", BASE + 12'h08, 32'h1);
  endtask

  task automatic testHold();
    cfgWrite(BASE + 12'h10, 4'hF, 32'd9);
    check("R9 numvfs write keeps active", {16'h0, activeVfs}, 32'd5);
    cfgWrite(BASE + 12'h08, 4'h1, 32'h1);
    check("R9 re-enable keeps active", {16'h0, activeVfs}, 32'd5);
    cfgWrite(BASE + 12'h08, 4'hE, 32'h0);
    check("R9 lane0 off keeps active", {16'h0, activeVfs}, 32'd5);
    check("R9 lane0 off keeps enable", {31'h0, vfEnable}, 32'h1);
  endtask

  task automatic testDisable();
    cfgWrite(BASE + 12'h08, 4'h1, 32'h0);
    check("R8 vfEnable cleared", {31'h0, vfEnable}, 32'h0);
    check("R8 active cleared", {16'h0, activeVfs}, 32'h0);
    readCheck("R8 numvfs cleared", BASE + 12'h10, 32'h0);
  endtask

  task automatic testOutside();
    cfgWrite(BASE + 12'h10, 4'hF, 32'd3);
    cfgWrite(BASE + 12'h48, 4'hF, 32'h1);
    cfgWrite(BASE - 12'h04, 4'hF, 32'h1);
    cfgWrite(BASE + 12'h50, 4'hF, 32'hFFFF);
    check("R10 enable untouched", {31'h0, vfEnable}, 32'h0);
    check("R10 active untouched", {16'h0, activeVfs}, 32'h0);
    readCheck("R10 numvfs untouched", BASE + 12'h10, 32'd3);
    readCheck("R10 read outside", BASE + 12'h48, 32'h0);
    readCheck("R10 read below", BASE - 12'h04, 32'h0);
  endtask

  task automatic testBars();
    cfgWrite(BASE + 12'h24, 4'hF, 32'hFFFF_FFFF);
    readCheck("R11 bar0 lo mask", BASE + 12'h24, 32'hFFFF_C00C);
    cfgWrite(BASE + 12'h28, 4'hF, 32'hFFFF_FFFF);
    readCheck("R11 bar0 hi full", BASE + 12'h28, 32'hFFFF_FFFF);
    cfgWrite(BASE + 12'h30, 4'hF, 32'h1234_5673);
    readCheck("R11 bar3 lo mask", BASE + 12'h30, 32'h1234_400C);
    cfgWrite(BASE + 12'h34, 4'hF, 32'hDEAD_BEEF);
    readCheck("R11 bar3 hi full", BASE + 12'h34, 32'hDEAD_BEEF);
    cfgWrite(BASE + 12'h2C, 4'hF, 32'hFFFF_FFFF);
    readCheck("R11 slot2 fixed", BASE + 12'h2C, 32'h0);
    cfgWrite(BASE + 12'h38, 4'hF, 32'hFFFF_FFFF);
    readCheck("R11 slot5 fixed", BASE + 12'h38, 32'h0);
    cfgWrite(BASE + 12'h24, 4'hF, 32'h0);
    readCheck("R11 bar0 lo type kept", BASE + 12'h24, 32'hC);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testConstants();
    testCtrlMask();
    testNumVfs();
    testPage();
    testByteEn();
    testEnable();
    testHold();
    testDisable();
    testOutside();
    testBars();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule